// File: doc/BRIEF.md
# Timer Count Snapshot and Byte Readback

This block gives an 8-bit processor a way to read three independent 16-bit down-counters without stopping them. The bus has two address bits and active-low chip-select, read and write strobes. Addresses 0, 1 and 2 reach the counters and address 3 is the command register. Every counter value passes over the bus as two bytes. Each counter keeps its own read pointer, so the low byte always comes first and the high byte second.

Software has two ways to read a counter. It can read the running value directly, which is reliable only while that counter is held still. It can also write a capture command first, which freezes a copy of the count in a per-counter holding register. Later reads then return the frozen copy while the counter keeps decrementing. After the high byte of the copy has been read, the holding register lets go. A counter is loaded with two byte writes. A load write that arrives between the low-byte and high-byte reads is refused and raises a sticky error flag.

The bus is sampled on the system clock. A write takes effect on the first clock edge that sees the write strobe high again after it was low. A read pointer moves on the first clock edge that sees the read strobe high again. Read data is combinational while the read strobe is low.

Top module: `timer_readback_top`

## Requirements
- R1: A read with cs_n and rd_n low at address 0, 1 or 2 drives dout_oe high and puts a byte of counter 0, 1 or 2 on dout. Outside such a read, dout_oe is low and dout is zero.
- R2: A read at address 3 keeps dout_oe low and does not change any read pointer or held copy.
- R3: The first completed read of a counter returns bits 7:0 and the next returns bits 15:8, after which the pointer returns to the low byte. Each counter has its own pointer, and reads of other counters leave it alone.
- R4: The first write to a counter address supplies bits 7:0 and the second supplies bits 15:8, and the counter takes the whole value on the second write. The counter drops by one on every clock where both its gate and cnt_en bits are high, wrapping from 0x0000 to 0xFFFF. Otherwise it holds.
- R5: A write to address 3 is a capture command only when din[5:4] is 00. The command targets the counter numbered by din[7:6], and din[3:0] has no effect. A target of 3 does nothing, and a write with any other din[5:4] value changes no counter, pointer or held copy.
- R6: A capture command stores the count as it stood just before the commit edge. Reads of that counter then return the stored copy while the counter keeps counting.
- R7: The held copy is released when its high byte has been read, and later reads return the running count.
- R8: A capture command for a counter whose copy is still held is ignored.
- R9: A load write to a counter whose low byte has been read but whose high byte has not is discarded. It does not advance the load byte order, and it sets that counter's seq_err bit, which stays set until reset.
- R10: After reset, all counts are zero, all pointers are at the low byte, no copy is held, seq_err is zero and dout_oe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| addr | input | 2 | 0-2 counter, 3 command register |
| din | input | 8 | Write data |
| cnt_en | input | 3 | Per-counter count clock enable |
| gate | input | 3 | Per-counter gate |
| dout | output | 8 | Read data |
| dout_oe | output | 1 | Read data valid / bus drive enable |
| seq_err | output | 3 | Sticky per-counter load-during-read flag |

## Verification
A capture command can commit on the same clock edge that decrements the counter it targets. The correct snapshot is the value from before that edge. The bench runs counter 2 continuously, issues the command at a cycle it has stamped, and compares the bytes read back with the load value minus the number of enabled edges between the load commit and the capture commit. A second collision puts a load write between the two byte reads. The bench judges it by the seq_err bit, by an unchanged high byte, and by a later clean load landing intact.

// File: rtl/timer_rb_pkg.sv
// Shared constants for the timer readback block.
// Assumes three counters, a two-bit address and an 8-bit data bus.
package timer_rb_pkg;
    localparam int DATA_W    = 8;
    localparam int CNT_W     = 2 * DATA_W;
    localparam int NUM_CH    = 3;
    localparam int ADDR_W    = 2;
    localparam logic [ADDR_W-1:0] CTRL_ADDR = '1;
    localparam logic [1:0] CAPTURE_CODE = 2'b00;
endpackage

// File: rtl/tmr_bus_if.sv
// Bus front end: registers the strobes and turns completed writes and
// reads into single-cycle per-counter strobes.
// Assumes the address, data and cs_n stay stable while a strobe is low.
module tmr_bus_if
    import timer_rb_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cs_n,
    input  logic                 rd_n,
    input  logic                 wr_n,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [DATA_W-1:0]    din,
    output logic [NUM_CH-1:0]    load_stb,
    output logic [NUM_CH-1:0]    capture_stb,
    output logic [NUM_CH-1:0]    rd_done,
    output logic [DATA_W-1:0]    wr_byte
);
    logic              cs_q;
    logic              rd_q;
    logic              wr_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] din_q;
    logic              wr_edge;
    logic              rd_edge;
    logic              capture_cmd;

    // Keep last cycle's bus state so strobe rising edges can be found.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_q   <= 1'b1;
            rd_q   <= 1'b1;
            wr_q   <= 1'b1;
            addr_q <= '0;
            din_q  <= '0;
        end else begin
            cs_q   <= cs_n;
            rd_q   <= rd_n;
            wr_q   <= wr_n;
            addr_q <= addr;
            din_q  <= din;
        end
    end

    // Write and read complete on the strobe rising edge.
    always_comb begin
        wr_edge     = !wr_q && wr_n && !cs_q;
        rd_edge     = !rd_q && rd_n && !cs_q;
        capture_cmd = wr_edge && (addr_q == CTRL_ADDR)
                      && (din_q[5:4] == CAPTURE_CODE);
        wr_byte     = din_q;
    end

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_dec
        // Route each completed access to the addressed counter.
        always_comb begin
            load_stb[ch]    = wr_edge && (addr_q == ADDR_W'(ch));
            capture_stb[ch] = capture_cmd && (din_q[7:6] == 2'(ch));
            rd_done[ch]     = rd_edge && (addr_q == ADDR_W'(ch));
        end
    end
endmodule

// File: rtl/tmr_channel.sv
// One counter with its two-byte loader, read pointer, snapshot holder and
// sequence guard. Assumes at most one strobe per cycle from the bus front end.
module tmr_channel
    import timer_rb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cnt_en,
    input  logic              load_stb,
    input  logic              capture_stb,
    input  logic              rd_done,
    input  logic [DATA_W-1:0] wr_byte,
    output logic [DATA_W-1:0] rd_byte,
    output logic              seq_err,
    output logic              held,
    output logic [CNT_W-1:0]  snap,
    output logic [CNT_W-1:0]  count
);
    logic              rd_hi;
    logic              wr_hi;
    logic [DATA_W-1:0] lo_buf;
    logic              load_ok;
    logic              load_fire;
    logic [CNT_W-1:0]  src;

    // A load byte is accepted only outside a two-byte read.
    always_comb begin
        load_ok   = load_stb && !rd_hi;
        load_fire = load_ok && wr_hi;
    end

    // Counter: a full load wins, otherwise decrement when enabled.
    always_ff @(posedge clk) begin
        if (!rst_n)
            count <= '0;
        else if (load_fire)
            count <= {wr_byte, lo_buf};
        else if (cnt_en)
            count <= count - 1'b1;
    end

    // Load byte order: keep the low byte, then wait for the high byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_hi  <= 1'b0;
            lo_buf <= '0;
        end else if (load_ok) begin
            if (!wr_hi)
                lo_buf <= wr_byte;
            wr_hi <= !wr_hi;
        end
    end

    // Read pointer toggles on every completed read of this counter.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rd_hi <= 1'b0;
        else if (rd_done)
            rd_hi <= !rd_hi;
    end

    // Snapshot: capture when free, release after the high byte is read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held <= 1'b0;
            snap <= '0;
        end else if (rd_done && rd_hi) begin
            held <= 1'b0;
        end else if (capture_stb && !held) begin
            held <= 1'b1;
            snap <= count;
        end
    end

    // Sticky flag for a load attempted in the middle of a read.
    always_ff @(posedge clk) begin
        if (!rst_n)
            seq_err <= 1'b0;
        else if (load_stb && rd_hi)
            seq_err <= 1'b1;
    end

    // Byte presented to the bus: held copy if any, else the live count.
    always_comb begin
        src     = held ? snap : count;
        rd_byte = rd_hi ? src[CNT_W-1:DATA_W] : src[DATA_W-1:0];
    end
endmodule

// File: rtl/timer_readback_top.sv
// Top: bus front end, three counters and the combinational read mux.
// Assumes a bus synchronous to clk; dout is valid only while dout_oe is high.
module timer_readback_top
    import timer_rb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              rd_n,
    input  logic              wr_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    input  logic [NUM_CH-1:0] cnt_en,
    input  logic [NUM_CH-1:0] gate,
    output logic [DATA_W-1:0] dout,
    output logic              dout_oe,
    output logic [NUM_CH-1:0] seq_err
);
    logic [NUM_CH-1:0]             load_stb;
    logic [NUM_CH-1:0]             capture_stb;
    logic [NUM_CH-1:0]             rd_done;
    logic [DATA_W-1:0]             wr_byte;
    logic [NUM_CH-1:0][DATA_W-1:0] ch_byte;
    logic [NUM_CH-1:0]             held_v;
    logic [NUM_CH-1:0][CNT_W-1:0]  snap_v;
    logic [NUM_CH-1:0][CNT_W-1:0]  count_v;

    tmr_bus_if u_bus (
        .clk         (clk),
        .rst_n       (rst_n),
        .cs_n        (cs_n),
        .rd_n        (rd_n),
        .wr_n        (wr_n),
        .addr        (addr),
        .din         (din),
        .load_stb    (load_stb),
        .capture_stb (capture_stb),
        .rd_done     (rd_done),
        .wr_byte     (wr_byte)
    );

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        tmr_channel u_chan (
            .clk         (clk),
            .rst_n       (rst_n),
            .cnt_en      (cnt_en[ch] && gate[ch]),
            .load_stb    (load_stb[ch]),
            .capture_stb (capture_stb[ch]),
            .rd_done     (rd_done[ch]),
            .wr_byte     (wr_byte),
            .rd_byte     (ch_byte[ch]),
            .seq_err     (seq_err[ch]),
            .held        (held_v[ch]),
            .snap        (snap_v[ch]),
            .count       (count_v[ch])
        );
    end

    // Read mux: drive only for a counter address during an active read.
    always_comb begin
        dout_oe = !cs_n && !rd_n && (addr != CTRL_ADDR);
        dout    = '0;
        for (int i = 0; i < NUM_CH; i++)
            if (dout_oe && (addr == ADDR_W'(i)))
                dout = ch_byte[i];
    end
endmodule

// File: rtl/timer_readback_chk.sv
// Assertion checker bound to timer_readback_top.
module timer_readback_chk
    import timer_rb_pkg::*;
(
    input logic                           clk,
    input logic                           rst_n,
    input logic                           cs_n,
    input logic                           rd_n,
    input logic                           wr_n,
    input logic [ADDR_W-1:0]              addr,
    input logic [NUM_CH-1:0]              cnt_en,
    input logic [NUM_CH-1:0]              gate,
    input logic                           dout_oe,
    input logic [NUM_CH-1:0]              seq_err,
    input logic [NUM_CH-1:0]              held_v,
    input logic [NUM_CH-1:0][CNT_W-1:0]   snap_v,
    input logic [NUM_CH-1:0][CNT_W-1:0]   count_v
);
    // R2
    ctrl_read_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && !rd_n && addr == CTRL_ADDR) |-> !dout_oe);

    for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
        // R9
        seq_err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
            seq_err[i] |=> seq_err[i]);
        // R8
        snap_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
            held_v[i] |=> (!held_v[i] || $stable(snap_v[i])));
        // R4
        count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!(gate[i] && cnt_en[i]) && !wr_n) |=> $stable(count_v[i]));
        // R7
        release_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(held_v[i]) |-> $past(!rd_n, 2));
    end
endmodule

bind timer_readback_top timer_readback_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .cs_n    (cs_n),
    .rd_n    (rd_n),
    .wr_n    (wr_n),
    .addr    (addr),
    .cnt_en  (cnt_en),
    .gate    (gate),
    .dout_oe (dout_oe),
    .seq_err (seq_err),
    .held_v  (held_v),
    .snap_v  (snap_v),
    .count_v (count_v)
);

// File: tb/timer_readback_top_tb_top.sv
module timer_readback_top_tb_top;
    logic       clk = 1'b0;
    logic       rst_n, cs_n, rd_n, wr_n;
    logic [1:0] addr;
    logic [7:0] din, dout;
    logic [2:0] cnt_en, gate, seq_err;
    logic       dout_oe;
    int         cyc = 0;
    int         checks = 0;
    int         fails = 0;
    logic [15:0] exp_cnt [3];

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    timer_readback_top dut_i (.clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n),
        .wr_n(wr_n), .addr(addr), .din(din), .cnt_en(cnt_en), .gate(gate),
        .dout(dout), .dout_oe(dout_oe), .seq_err(seq_err));

    function automatic logic [7:0] cap_cmd(int ch, logic [3:0] low);
        return {2'(ch), 2'b00, low};
    endfunction

    task automatic chk(bit ok, string tag, int act, int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s act=%h exp=%h", tag, act, expv);
        end
    endtask

    // Write one byte; stamp is the cycle count just before the commit edge.
    task automatic bus_wr(input logic [1:0] a, input logic [7:0] d, output int stamp);
        @(negedge clk); cs_n = 0; addr = a; din = d; wr_n = 0;
        @(negedge clk); wr_n = 1; stamp = cyc;
        @(negedge clk); cs_n = 1;
    endtask

    task automatic bus_rd(input logic [1:0] a, output logic [7:0] d, output logic oe);
        @(negedge clk); cs_n = 0; addr = a; rd_n = 0;
        #2; d = dout; oe = dout_oe;
        @(negedge clk); rd_n = 1;
        @(negedge clk); cs_n = 1;
    endtask

    task automatic load(int ch, logic [15:0] v, output int stamp);
        int s;
        bus_wr(2'(ch), v[7:0], s);
        bus_wr(2'(ch), v[15:8], stamp);
    endtask

    task automatic check_word(int ch, logic [15:0] expv, string tag);
        logic [7:0] lo, hi;
        logic oe1, oe2;
        bus_rd(2'(ch), lo, oe1);
        bus_rd(2'(ch), hi, oe2);
        chk(oe1 && oe2, tag, {oe1, oe2}, 2'b11);
        chk({hi, lo} == expv, tag, {hi, lo}, expv);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired act=%0d exp=done", cyc);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [7:0] b;
        logic oe;
        int s, sa, sb;
        logic [15:0] v;
        void'($urandom(32'd7));
        rst_n = 0; cs_n = 1; rd_n = 1; wr_n = 1; addr = 0; din = 0;
        gate = 0; cnt_en = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R10 reset state
        chk(!dout_oe && seq_err == 0, "R10 reset outputs", {dout_oe, seq_err}, 0);
        for (int c = 0; c < 3; c++) begin check_word(c, 16'h0, "R10 count zero"); exp_cnt[c] = 0; end

        // R4 two-byte load, R1 decode, R3 byte order
        load(0, 16'h1234, s); load(1, 16'hABCD, s); load(2, 16'h00FF, s);
        exp_cnt[0] = 16'h1234; exp_cnt[1] = 16'hABCD; exp_cnt[2] = 16'h00FF;
        for (int c = 0; c < 3; c++) check_word(c, exp_cnt[c], "R1 R3 R4 load/readback");

        // R3 independent pointers
        bus_rd(0, b, oe); chk(b == 8'h34, "R3 ch0 low", b, 8'h34);
        check_word(1, 16'hABCD, "R3 other counter");
        bus_rd(0, b, oe); chk(b == 8'h12, "R3 ch0 high kept", b, 8'h12);

        // R2 illegal read
        bus_rd(1, b, oe); chk(b == 8'hCD, "R2 ch1 low", b, 8'hCD);
        bus_rd(3, b, oe); chk(!oe && b == 0, "R2 ctrl read undriven", {oe, b}, 0);
        bus_rd(1, b, oe); chk(b == 8'hAB, "R2 pointer unchanged", b, 8'hAB);

        // R5 low bits ignored, R6 snapshot, R8 second capture ignored, R7 release
        bus_wr(3, cap_cmd(0, 4'hF), s);
        load(0, 16'h5555, s);
        bus_wr(3, cap_cmd(0, 4'h0), s);
        check_word(0, 16'h1234, "R6 R8 snapshot held");
        check_word(0, 16'h5555, "R7 released to live");
        exp_cnt[0] = 16'h5555;

        // R5 non-capture code and target 3 do nothing
        bus_wr(3, 8'h76, s);
        load(1, 16'h0F0F, s); exp_cnt[1] = 16'h0F0F;
        check_word(1, 16'h0F0F, "R5 other code no capture");
        bus_wr(3, 8'hC0, s);
        load(0, 16'h2222, s); exp_cnt[0] = 16'h2222;
        for (int c = 0; c < 3; c++) check_word(c, exp_cnt[c], "R5 target 3 ignored");

        // R9 load during a read
        bus_rd(2, b, oe); chk(b == 8'hFF, "R9 low first", b, 8'hFF);
        bus_wr(2, 8'h77, s);
        chk(seq_err == 3'b100, "R9 flag set", seq_err, 3'b100);
        bus_rd(2, b, oe); chk(b == 8'h00, "R9 load discarded", b, 8'h00);
        load(2, 16'h1357, s);
        check_word(2, 16'h1357, "R9 byte order intact");
        chk(seq_err == 3'b100, "R9 sticky", seq_err, 3'b100);

        // R6 capture on a decrementing edge
        @(negedge clk); gate[2] = 1; cnt_en[2] = 1;
        load(2, 16'h0100, sa);
        repeat (7) @(negedge clk);
        bus_wr(3, cap_cmd(2, 4'h5), sb);
        repeat (5) @(negedge clk);
        v = 16'h0100 - 16'(sb - sa - 1);
        check_word(2, v, "R6 capture while counting");

        // R4 wrap through zero, then hold when enable is low
        load(2, 16'h0003, sa);
        repeat (10) @(negedge clk);
        gate[2] = 0; s = cyc;
        v = 16'h0003 - 16'(s - sa - 1);
        check_word(2, v, "R4 wrap below zero");
        gate[2] = 1; cnt_en[2] = 0;
        repeat (6) @(negedge clk);
        check_word(2, v, "R4 hold without enable");
        gate = 0; exp_cnt[2] = v;

        // Random mix with counting stopped
        for (int it = 0; it < 60; it++) begin
            int ch = int'($urandom % 3);
            int op = int'($urandom % 4);
            logic [15:0] nv = 16'($urandom);
            case (op)
                0: begin load(ch, nv, s); exp_cnt[ch] = nv; end
                1: check_word(ch, exp_cnt[ch], "R3 R4 random readback");
                2: begin
                    bus_wr(3, cap_cmd(ch, 4'($urandom)), s);
                    load(ch, nv, s);
                    check_word(ch, exp_cnt[ch], "R6 random snapshot");
                    exp_cnt[ch] = nv;
                    check_word(ch, nv, "R7 random release");
                end
                default: begin
                    bus_wr(3, {2'(ch), 2'(1 + $urandom % 3), 4'($urandom)}, s);
                    load(ch, nv, s); exp_cnt[ch] = nv;
                    check_word(ch, nv, "R5 random non-capture");
                end
            endcase
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule